// File: doc/BRIEF.md
# Jacobian Prime-Field Point Doubler

This block doubles a point on the short Weierstrass curve y² = x³ + a·x + b over a prime field GF(p). The point is held in Jacobian form, where the affine coordinates are x = X/Z² and y = Y/Z³. Because the doubling stays projective, no field inversion is needed.

A caller presents X1, Y1, Z1, the curve coefficient a and the modulus p, then pulses `start`. The block runs a fixed schedule of 23 field operations, one at a time:

- Multiplications and squarings go to one shared bit-serial modular multiplier.
- Additions and subtractions go to a single-cycle modular add/sub unit.
- The constant multiples 2, 3, 4 and 8 are built from repeated modular additions.

When the schedule ends, `done` pulses for one cycle and X4, Y4, Z4 hold the doubled point. The results stay on the outputs until the next accepted `start`.

The operand width is a parameter, 192 bits by default. All inputs must already be reduced, that is smaller than p, and p must be an odd prime below 2^W.

Top module: `jacDoubler`

## Requirements
- R1: A `start` pulse while idle captures x1, y1, z1, curveA and prime and begins a doubling. `done` later rises for one cycle with the results.
- R2: At `done`, x4 equals A² − 2·B mod p, where A = 3·X1² + a·Z1⁴ mod p and B = 4·X1·Y1² mod p.
- R3: At `done`, z4 equals 2·Y1·Z1 mod p.
- R4: At `done`, y4 equals A·(B − X4) − 8·Y1⁴ mod p.
- R5: Every intermediate and final value lies in [0, p). A modular sum that reaches p has p subtracted, and a negative modular difference has p added.
- R6: An input with Y1 = 0 or Z1 = 0 gives the point at infinity, encoded as z4 = 0.
- R7: `done` is high for exactly one cycle. x4, y4 and z4 stay unchanged from `done` until the next accepted `start`.
- R8: A `start` raised while a doubling is in progress is ignored. The running doubling finishes with its original operands.
- R9: The width parameter W sets all operand widths (default 192). Full-width moduli near 2^192 with operands up to p − 1 are handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a doubling; accepted only while idle |
| x1 | input | W | Input Jacobian X |
| y1 | input | W | Input Jacobian Y |
| z1 | input | W | Input Jacobian Z |
| curveA | input | W | Curve coefficient a, reduced mod p |
| prime | input | W | Field modulus p |
| done | output | 1 | One-cycle completion pulse |
| x4 | output | W | Result Jacobian X |
| y4 | output | W | Result Jacobian Y |
| z4 | output | W | Result Jacobian Z (0 for infinity) |

## Verification
The checker verifies on every cycle that:
- every multiplier result and every add/sub result written back is below the captured modulus;
- an idle `start` always makes the block busy;
- `done` never lasts two cycles;
- the outputs do not move while the block sits idle.

Only the bench scenarios can show the rest, by comparing against an independent wide-integer model:
- the arithmetic correctness of X4, Y4 and Z4, including the wrap-around cases on a small prime and on a full 192-bit modulus;
- the infinity encoding for Y1 = 0 and Z1 = 0;
- that a mid-run `start` carrying different operands leaves the result untouched.

// File: rtl/jacDoublerPkg.sv
package jacDoublerPkg;

  typedef enum logic [3:0] {
    RX = 4'd0, RY = 4'd1, RZ = 4'd2, RA = 4'd3,
    T0 = 4'd4, T1 = 4'd5, T2 = 4'd6, T3 = 4'd7, T4 = 4'd8, T5 = 4'd9
  } regSel_e;

  localparam int NREG   = 10;
  localparam int NSTEPS = 23;
  localparam int SW     = $clog2(NSTEPS);

  typedef enum logic [1:0] {OP_MUL = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2} op_e;

  typedef struct packed {
    op_e     op;
    regSel_e dst;
    regSel_e sa;
    regSel_e sb;
  } step_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    mulGo;
    logic    wrAlu;
    logic    wrMul;
    logic    sub;
    regSel_e srcA;
    regSel_e srcB;
    regSel_e dst;
  } dpCtrl_t;

  // Doubling schedule. Outputs: X4 in T0, Y4 in T5, Z4 in T3.
  function automatic step_t stepAt(input logic [SW-1:0] idx);
    step_t s;
    case (idx)
      5'd0:    s = '{OP_MUL, T0, RX, RX};  // X^2
      5'd1:    s = '{OP_ADD, T1, T0, T0};  // 2X^2
      5'd2:    s = '{OP_ADD, T1, T1, T0};  // 3X^2
      5'd3:    s = '{OP_MUL, T2, RZ, RZ};  // Z^2
      5'd4:    s = '{OP_MUL, T2, T2, T2};  // Z^4
      5'd5:    s = '{OP_MUL, T2, RA, T2};  // a*Z^4
      5'd6:    s = '{OP_ADD, T1, T1, T2};  // A
      5'd7:    s = '{OP_MUL, T3, RY, RZ};  // Y*Z
      5'd8:    s = '{OP_ADD, T3, T3, T3};  // Z4
      5'd9:    s = '{OP_MUL, T4, RY, RY};  // Y^2
      5'd10:   s = '{OP_MUL, T2, RX, T4};  // X*Y^2
      5'd11:   s = '{OP_ADD, T2, T2, T2};
      5'd12:   s = '{OP_ADD, T2, T2, T2};  // B
      5'd13:   s = '{OP_MUL, T4, T4, T4};  // Y^4
      5'd14:   s = '{OP_ADD, T4, T4, T4};
      5'd15:   s = '{OP_ADD, T4, T4, T4};
      5'd16:   s = '{OP_ADD, T4, T4, T4};  // C
      5'd17:   s = '{OP_MUL, T0, T1, T1};  // A^2
      5'd18:   s = '{OP_SUB, T0, T0, T2};
      5'd19:   s = '{OP_SUB, T0, T0, T2};  // X4
      5'd20:   s = '{OP_SUB, T5, T2, T0};  // B - X4
      5'd21:   s = '{OP_MUL, T5, T1, T5};
      default: s = '{OP_SUB, T5, T5, T4};  // Y4
    endcase
    return s;
  endfunction

endpackage

// File: rtl/jacModMul.sv
// Bit-serial MSB-first modular multiplier: one operand bit per cycle.
module jacModMul #(
  parameter int W = 192
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modP,
  output logic         fin,
  output logic [W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  accR, aR, bR;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    pExt, dbl, red1, sum, sumSub;
  logic [W-1:0]  accNext;

  always_comb begin
    pExt   = {1'b0, modP};
    dbl    = {accR, 1'b0};
    red1   = (dbl >= pExt) ? dbl - pExt : dbl;
    sum    = red1 + {1'b0, (bR[W-1] ? aR : '0)};
    sumSub = sum - pExt;
    accNext = (sum >= pExt) ? sumSub[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accR <= '0; aR <= '0; bR <= '0; cnt <= '0; run <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        accR <= '0;
        aR   <= opA;
        bR   <= opB;
        cnt  <= CW'(W);
        run  <= 1'b1;
      end else if (run) begin
        accR <= accNext;
        bR   <= bR << 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign prod = accR;
endmodule

// File: rtl/jacModAddSub.sv
module jacModAddSub #(
  parameter int W = 192
) (
  input  logic         sub,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modP,
  output logic [W-1:0] res
);
  logic [W:0]   pExt, sumF, sumR, diff;
  logic [W-1:0] addRes, diffWrap;

  always_comb begin
    pExt     = {1'b0, modP};
    sumF     = {1'b0, opA} + {1'b0, opB};
    sumR     = sumF - pExt;
    addRes   = (sumF >= pExt) ? sumR[W-1:0] : sumF[W-1:0];
    diff     = {1'b0, opA} - {1'b0, opB};
    diffWrap = diff[W-1:0] + modP;
    if (sub) res = diff[W] ? diffWrap : diff[W-1:0];
    else     res = addRes;
  end
endmodule

// File: rtl/jacDblPath.sv
module jacDblPath
  import jacDoublerPkg::*;
#(
  parameter int W = 192
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctl,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] y1,
  input  logic [W-1:0] z1,
  input  logic [W-1:0] curveA,
  input  logic [W-1:0] prime,
  output logic         mulDone,
  output logic [W-1:0] mulRes,
  output logic [W-1:0] aluRes,
  output logic [W-1:0] pHold,
  output logic [W-1:0] x4,
  output logic [W-1:0] y4,
  output logic [W-1:0] z4
);
  logic [W-1:0] regs [NREG];
  logic [W-1:0] opA, opB;

  assign opA = regs[ctl.srcA];
  assign opB = regs[ctl.srcB];

  jacModMul #(.W(W)) mul_i (
    .clk(clk), .rstN(rstN), .go(ctl.mulGo), .opA(opA), .opB(opB),
    .modP(pHold), .fin(mulDone), .prod(mulRes)
  );

  jacModAddSub #(.W(W)) alu_i (
    .sub(ctl.sub), .opA(opA), .opB(opB), .modP(pHold), .res(aluRes)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      pHold <= '0;
    end else begin
      if (ctl.load) begin
        regs[RX] <= x1;
        regs[RY] <= y1;
        regs[RZ] <= z1;
        regs[RA] <= curveA;
        pHold    <= prime;
      end
      if (ctl.wrAlu)      regs[ctl.dst] <= aluRes;
      else if (ctl.wrMul) regs[ctl.dst] <= mulRes;
    end
  end

  assign x4 = regs[T0];
  assign y4 = regs[T5];
  assign z4 = regs[T3];
endmodule

// File: rtl/jacDblCtrl.sv
module jacDblCtrl
  import jacDoublerPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    mulDone,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    done
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT, S_DONE} state_e;

  state_e        state;
  logic [SW-1:0] stepIdx;
  step_t         cur;
  logic          lastStep;

  assign cur      = stepAt(stepIdx);
  assign lastStep = (stepIdx == SW'(NSTEPS - 1));

  always_comb begin
    ctl      = '0;
    ctl.srcA = cur.sa;
    ctl.srcB = cur.sb;
    ctl.dst  = cur.dst;
    ctl.sub  = (cur.op == OP_SUB);
    case (state)
      S_IDLE: ctl.load = start;
      S_EXEC: begin
        if (cur.op == OP_MUL) ctl.mulGo = 1'b1;
        else                  ctl.wrAlu = 1'b1;
      end
      S_WAIT: ctl.wrMul = mulDone;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_EXEC;
          stepIdx <= '0;
        end
        S_EXEC: begin
          if (cur.op == OP_MUL) state <= S_WAIT;
          else if (lastStep)    state <= S_DONE;
          else                  stepIdx <= stepIdx + 1'b1;
        end
        S_WAIT: if (mulDone) begin
          if (lastStep) state <= S_DONE;
          else begin
            state   <= S_EXEC;
            stepIdx <= stepIdx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/jacDoubler.sv
module jacDoubler
  import jacDoublerPkg::*;
#(
  parameter int W = 192
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] y1,
  input  logic [W-1:0] z1,
  input  logic [W-1:0] curveA,
  input  logic [W-1:0] prime,
  output logic         done,
  output logic [W-1:0] x4,
  output logic [W-1:0] y4,
  output logic [W-1:0] z4
);
  dpCtrl_t      ctl;
  logic         busyInt, mulDone, wrAluInt;
  logic [W-1:0] mulRes, aluRes, pHold;

  assign wrAluInt = ctl.wrAlu;

  jacDblCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .mulDone(mulDone),
    .ctl(ctl), .busy(busyInt), .done(done)
  );

  jacDblPath #(.W(W)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .x1(x1), .y1(y1), .z1(z1), .curveA(curveA), .prime(prime),
    .mulDone(mulDone), .mulRes(mulRes), .aluRes(aluRes), .pHold(pHold),
    .x4(x4), .y4(y4), .z4(z4)
  );
endmodule

// File: rtl/jacDoublerChk.sv
module jacDoublerChk #(
  parameter int W = 192
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         done,
  input logic         busyInt,
  input logic         mulDone,
  input logic         wrAluInt,
  input logic [W-1:0] mulRes,
  input logic [W-1:0] aluRes,
  input logic [W-1:0] pHold,
  input logic [W-1:0] x4,
  input logic [W-1:0] y4,
  input logic [W-1:0] z4
);
  p_start_begins_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busyInt && start) |=> busyInt);

  p_mul_reduced_r5: assert property (@(posedge clk) disable iff (!rstN)
    mulDone |-> (mulRes < pHold));

  p_alu_reduced_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrAluInt |-> (aluRes < pHold));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busyInt && !start) |=> ($stable(x4) && $stable(y4) && $stable(z4)));

  p_done_while_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busyInt);
endmodule

bind jacDoubler jacDoublerChk #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .busyInt(busyInt),
  .mulDone(mulDone), .wrAluInt(wrAluInt), .mulRes(mulRes), .aluRes(aluRes),
  .pHold(pHold), .x4(x4), .y4(y4), .z4(z4)
);

// File: tb/jacDoubler_tb_top.sv
module jacDoubler_tb_top;
  localparam int W = 192;
  localparam int NV = 5;
  localparam logic [W-1:0] P192 = 192'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFEFFFFFFFFFFFFFFFF;

  // stimulus table: prime, a, X1, Y1, Z1
  localparam logic [W-1:0] TP [NV] = '{192'd23, 192'd23, P192, 192'd1000003, P192};
  localparam logic [W-1:0] TA [NV] = '{192'd1, 192'd1, P192 - 192'd3, 192'd0, 192'd5};
  localparam logic [W-1:0] TX [NV] = '{192'd3, 192'd7, 192'h188DA80EB03090F67CBF20EB43A18800F4FF0AFD82FF1012,
                                       192'd12345, P192 - 192'd1};
  localparam logic [W-1:0] TY [NV] = '{192'd10, 192'd22, 192'h07192B95FFC8DA78631011ED6B24CDD573F977A11E794811,
                                       192'd67890, P192 - 192'd2};
  localparam logic [W-1:0] TZ [NV] = '{192'd1, 192'd5, 192'h64210519E59C80E70FA7E9AB72243049FEB8DEECC146B9B1,
                                       192'd424242, P192 - 192'd1};

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [W-1:0] x1 = '0, y1 = '0, z1 = '0, curveA = '0, prime = '0;
  logic done;
  logic [W-1:0] x4, y4, z4;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  jacDoubler #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .x1(x1), .y1(y1), .z1(z1),
    .curveA(curveA), .prime(prime), .done(done), .x4(x4), .y4(y4), .z4(z4)
  );

  function automatic logic [W-1:0] mm(input logic [W-1:0] a, b, p);
    logic [2*W-1:0] t;
    t = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    t = t % {{W{1'b0}}, p};
    return t[W-1:0];
  endfunction
  function automatic logic [W-1:0] am(input logic [W-1:0] a, b, p);
    logic [W:0] t;
    t = ({1'b0, a} + {1'b0, b}) % {1'b0, p};
    return t[W-1:0];
  endfunction
  function automatic logic [W-1:0] sm(input logic [W-1:0] a, b, p);
    logic [W:0] t;
    t = ({1'b0, a} + {1'b0, p} - {1'b0, b}) % {1'b0, p};
    return t[W-1:0];
  endfunction

  logic [W-1:0] eX, eY, eZ;
  task automatic model(input logic [W-1:0] x, y, z, a, p);
    logic [W-1:0] ta, tb, tc, y2;
    ta = am(mm(192'd3, mm(x, x, p), p), mm(a, mm(mm(z, z, p), mm(z, z, p), p), p), p);
    y2 = mm(y, y, p);
    tb = mm(192'd4, mm(x, y2, p), p);
    tc = mm(192'd8, mm(y2, y2, p), p);
    eX = sm(mm(ta, ta, p), mm(192'd2, tb, p), p);
    eZ = mm(192'd2, mm(y, z, p), p);
    eY = sm(mm(ta, sm(tb, eX, p), p), tc, p);
  endtask

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] x, y, z, a, p);
    @(negedge clk);
    x1 = x; y1 = y; z1 = z; curveA = a; prime = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic checkResult(input string tag);
    chk(x4 == eX, {tag, " R2 x4"}, x4, eX);
    chk(y4 == eY, {tag, " R4 y4"}, y4, eY);
    chk(z4 == eZ, {tag, " R3 z4"}, z4, eZ);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [W-1:0] hx, hy, hz;
    repeat (3) @(negedge clk);
    // reset state
    chk(done == 1'b0, "reset R1 done", {191'd0, done}, '0);
    chk(x4 == '0 && z4 == '0, "reset R7 outputs", x4, '0);
    rstN = 1'b1;

    // table walk (R9 covers the full-width rows)
    for (int v = 0; v < NV; v++) begin
      model(TX[v], TY[v], TZ[v], TA[v], TP[v]);
      launch(TX[v], TY[v], TZ[v], TA[v], TP[v]);
      waitDone(seen);
      chk(seen, "table R1 done seen", {191'd0, seen}, 192'd1);
      checkResult(v >= 2 ? "table R9" : "table R5");
      @(negedge clk);
      chk(done == 1'b0, "table R7 single pulse", {191'd0, done}, '0);
    end

    // hand-worked vector on p=23: wrap in add and subtract (R5)
    launch(192'd3, 192'd10, 192'd1, 192'd1, 192'd23);
    waitDone(seen);
    chk(x4 == 192'd17, "hand R2 R5", x4, 192'd17);
    chk(y4 == 192'd21, "hand R4 R5", y4, 192'd21);
    chk(z4 == 192'd20, "hand R3", z4, 192'd20);
    // outputs hold while idle
    hx = x4; hy = y4; hz = z4;
    repeat (8) @(negedge clk);
    chk(x4 == hx && y4 == hy && z4 == hz, "hold R7", x4, hx);
    chk(done == 1'b0, "idle R7 no done", {191'd0, done}, '0);

    // infinity cases
    launch(192'd50, 192'd0, 192'd7, 192'd96, 192'd97);
    waitDone(seen);
    chk(z4 == '0, "Y1=0 R6", z4, '0);
    launch(192'd50, 192'd30, 192'd0, 192'd96, 192'd97);
    waitDone(seen);
    chk(z4 == '0, "Z1=0 R6", z4, '0);

    // start during run is ignored
    model(TX[3], TY[3], TZ[3], TA[3], TP[3]);
    launch(TX[3], TY[3], TZ[3], TA[3], TP[3]);
    repeat (300) @(negedge clk);
    x1 = 192'd5; y1 = 192'd6; z1 = 192'd7; curveA = 192'd1; prime = 192'd23; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    chk(seen, "ignore R8 done", {191'd0, seen}, 192'd1);
    checkResult("ignore R8");
    @(negedge clk);
    chk(done == 1'b0, "ignore R8 no restart", {191'd0, done}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule